// File: doc/BRIEF.md
# Split Encryption Counter Line Manager

This block keeps one counter line for counter-mode memory encryption. A line covers a page of 64 data blocks. Each block has its own narrow counter, and the whole page shares one wide counter. Each accepted write names a block. The block bumps that block's counter and returns the new narrow and wide values. It also returns the initialization vector that an external cipher would turn into a pad. The cipher, the data path and the counter cache sit outside.

A narrow counter can run out of values. When it does, the block advances the shared counter and clears every narrow counter in the page. It then sends a one-cycle request to re-encrypt the whole page and refuses further writes until that work is acknowledged. If the shared counter wraps at the same moment, a key-change request goes out with the re-encryption request. A line fetched from memory can be loaded in one cycle. The packed line image is always visible for write-back, and a dirty flag marks it as changed since the last load or write-back.

Top module: `ctr_line_mgr`

## Requirements
- R1: After reset the line image is all zeros, and `rsp_valid`, `reenc_req`, `key_req`, `busy` and `dirty` are all low.
- R2: A write is accepted when `wr_valid` is high, `busy` is low and `ld_valid` is low. On the next cycle `rsp_valid` is high for one cycle. `rsp_minor` then holds the block's counter plus one, `rsp_major` holds the unchanged page counter, and no other block's counter moves.
- R3: The line image puts the page counter in bits [511:448] and the counter of block i in bits [7i+6:7i].
- R4: `rsp_iv` is 113 bits: page identifier in [112:77], block index in [76:71], new block counter in [70:64], new page counter in [63:0].
- R5: A write to a block whose counter is 127 raises the page counter by one and clears every block counter to 0. The written block then gets 1, and the response reports 1 and the new page counter.
- R6: The event in R5 makes `reenc_req` high for exactly one cycle, together with the response, with `reenc_page` equal to the loaded page identifier. `busy` rises in the same cycle and stays high until the cycle after `reenc_ack` is sampled high.
- R7: While `busy` is high, a write gives no response and leaves the line image unchanged.
- R8: If the page counter is all ones when R5 occurs, it wraps to 0, and `key_req` pulses for one cycle at the same time as `reenc_req`.
- R9: `ld_valid` replaces the line image and page identifier on the next cycle and clears `dirty`. A write presented in the same cycle is ignored.
- R10: An accepted write sets `dirty`. `wb_ack` clears it on the next cycle unless a write is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load a line from memory |
| ld_line | input | 512 | Line image to load |
| ld_page | input | 36 | Page identifier for the loaded line |
| wr_valid | input | 1 | Write request |
| wr_idx | input | 6 | Block index of the write |
| reenc_ack | input | 1 | Page re-encryption finished |
| wb_ack | input | 1 | Line image written back |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_minor | output | 7 | New block counter |
| rsp_major | output | 64 | Page counter used for the write |
| rsp_iv | output | 113 | Initialization vector for the write |
| reenc_req | output | 1 | Page re-encryption request pulse |
| reenc_page | output | 36 | Page identifier of the line |
| key_req | output | 1 | Key regeneration request pulse |
| busy | output | 1 | Writes refused until re-encryption acknowledge |
| dirty | output | 1 | Line changed since last load or write-back |
| line_out | output | 512 | Packed line image |

## Verification
The bench drives one block's counter from 126 up through 127 and into the wrap. A design that let the counter wrap silently to 0 would reuse a pad. One that set the written block to 0 instead of 1 would collide with the page re-encryption. The bench writes during `busy` to catch a design that lets a write slip past the hold. It loads a page counter of all ones to show that the key request goes out with the re-encryption request. It presents a load and a write in the same cycle to catch a design that lets the write win. A bad bit layout would show up as a wrong line image or vector, and a wrong dirty rule as a flag out of step with write-back.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   typedef enum logic [1:0] {
      WRAP_NONE  = 2'd0,
      WRAP_MINOR = 2'd1,
      WRAP_MAJOR = 2'd2
   } wrap_kind_e;
endpackage

// File: rtl/ctr_minor_bank.sv
// Per-block narrow counters; wraps of the selected block clear the bank.
module ctr_minor_bank #(
   parameter int NUM_BLOCKS = 64,
   parameter int MINOR_W    = 7,
   localparam int IDX_W     = $clog2(NUM_BLOCKS),
   localparam int BANK_W    = NUM_BLOCKS * MINOR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic [BANK_W-1:0]  load_bank,
   input  logic               upd_en,
   input  logic [IDX_W-1:0]   upd_idx,
   output logic [BANK_W-1:0]  bank,
   output logic [MINOR_W-1:0] sel_cur,
   output logic               sel_full
);
   logic [MINOR_W-1:0] cnt_arr [NUM_BLOCKS];

   assign sel_cur  = cnt_arr[upd_idx];
   assign sel_full = &sel_cur;

   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
      logic [MINOR_W-1:0] cnt_q;
      logic               hit;
      assign hit = (upd_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (load_en) begin
            cnt_q <= load_bank[i*MINOR_W +: MINOR_W];
         end else if (upd_en) begin
            if (sel_full)
               cnt_q <= hit ? MINOR_W'(1) : '0;
            else if (hit)
               cnt_q <= cnt_q + 1'b1;
         end
      end
      assign cnt_arr[i] = cnt_q;
      assign bank[i*MINOR_W +: MINOR_W] = cnt_q;
   end
endmodule

// File: rtl/ctr_major_reg.sv
// Shared wide page counter.
module ctr_major_reg #(
   parameter int MAJOR_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic [MAJOR_W-1:0] load_val,
   input  logic               bump,
   output logic [MAJOR_W-1:0] major,
   output logic [MAJOR_W-1:0] major_nxt,
   output logic               at_max
);
   logic [MAJOR_W-1:0] major_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       major_q <= '0;
      else if (load_en) major_q <= load_val;
      else if (bump)    major_q <= major_nxt;
   end

   assign major     = major_q;
   assign major_nxt = major_q + 1'b1;
   assign at_max    = &major_q;
endmodule

// File: rtl/ctr_iv_pack.sv
// Concatenates the vector fields, most significant first.
module ctr_iv_pack #(
   parameter int PAGE_ID_W = 36,
   parameter int IDX_W     = 6,
   parameter int MINOR_W   = 7,
   parameter int MAJOR_W   = 64,
   localparam int IV_W     = PAGE_ID_W + IDX_W + MINOR_W + MAJOR_W
) (
   input  logic [PAGE_ID_W-1:0] page,
   input  logic [IDX_W-1:0]     idx,
   input  logic [MINOR_W-1:0]   minor,
   input  logic [MAJOR_W-1:0]   major,
   output logic [IV_W-1:0]      iv
);
   assign iv = {page, idx, minor, major};
endmodule

// File: rtl/ctr_line_mgr.sv
module ctr_line_mgr #(
   parameter int NUM_BLOCKS = 64,
   parameter int MINOR_W    = 7,
   parameter int MAJOR_W    = 64,
   parameter int PAGE_ID_W  = 36,
   localparam int IDX_W     = $clog2(NUM_BLOCKS),
   localparam int BANK_W    = NUM_BLOCKS * MINOR_W,
   localparam int LINE_W    = BANK_W + MAJOR_W,
   localparam int IV_W      = PAGE_ID_W + IDX_W + MINOR_W + MAJOR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_valid,
   input  logic [LINE_W-1:0]    ld_line,
   input  logic [PAGE_ID_W-1:0] ld_page,
   input  logic                 wr_valid,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic                 reenc_ack,
   input  logic                 wb_ack,
   output logic                 rsp_valid,
   output logic [MINOR_W-1:0]   rsp_minor,
   output logic [MAJOR_W-1:0]   rsp_major,
   output logic [IV_W-1:0]      rsp_iv,
   output logic                 reenc_req,
   output logic [PAGE_ID_W-1:0] reenc_page,
   output logic                 key_req,
   output logic                 busy,
   output logic                 dirty,
   output logic [LINE_W-1:0]    line_out
);
   import ctr_pkg::*;

   if ((1 << IDX_W) != NUM_BLOCKS) begin : g_bad_blocks
      $error("NUM_BLOCKS must be a power of two");
   end
   if (MINOR_W < 2) begin : g_bad_minor
      $error("MINOR_W must be at least 2");
   end
   if (PAGE_ID_W < 1 || MAJOR_W < 2) begin : g_bad_widths
      $error("PAGE_ID_W and MAJOR_W out of range");
   end

   logic               accept;
   logic [BANK_W-1:0]  bank;
   logic [MINOR_W-1:0] sel_cur;
   logic               sel_full;
   logic [MAJOR_W-1:0] major, major_nxt;
   logic               major_max;
   logic [MINOR_W-1:0] new_minor;
   logic [MAJOR_W-1:0] new_major;
   logic [IV_W-1:0]    new_iv;
   logic [PAGE_ID_W-1:0] page_q;
   logic               busy_q, dirty_q;
   wrap_kind_e         wrap_kind;

   assign accept = wr_valid & ~busy_q & ~ld_valid;

   ctr_minor_bank #(.NUM_BLOCKS(NUM_BLOCKS), .MINOR_W(MINOR_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .load_en(ld_valid), .load_bank(ld_line[BANK_W-1:0]),
      .upd_en(accept), .upd_idx(wr_idx),
      .bank(bank), .sel_cur(sel_cur), .sel_full(sel_full)
   );

   ctr_major_reg #(.MAJOR_W(MAJOR_W)) u_major (
      .clk(clk), .rst_n(rst_n),
      .load_en(ld_valid), .load_val(ld_line[LINE_W-1:BANK_W]),
      .bump(accept & sel_full),
      .major(major), .major_nxt(major_nxt), .at_max(major_max)
   );

   always_comb begin
      if (!accept || !sel_full) wrap_kind = WRAP_NONE;
      else if (major_max)       wrap_kind = WRAP_MAJOR;
      else                      wrap_kind = WRAP_MINOR;
   end

   assign new_minor = sel_full ? MINOR_W'(1) : sel_cur + 1'b1;
   assign new_major = sel_full ? major_nxt : major;

   ctr_iv_pack #(.PAGE_ID_W(PAGE_ID_W), .IDX_W(IDX_W),
                 .MINOR_W(MINOR_W), .MAJOR_W(MAJOR_W)) u_iv (
      .page(page_q), .idx(wr_idx), .minor(new_minor), .major(new_major),
      .iv(new_iv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_minor <= '0;
         rsp_major <= '0;
         rsp_iv    <= '0;
         reenc_req <= 1'b0;
         key_req   <= 1'b0;
         busy_q    <= 1'b0;
         dirty_q   <= 1'b0;
         page_q    <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_minor <= new_minor;
            rsp_major <= new_major;
            rsp_iv    <= new_iv;
         end
         reenc_req <= (wrap_kind != WRAP_NONE);
         key_req   <= (wrap_kind == WRAP_MAJOR);
         if (wrap_kind != WRAP_NONE) busy_q <= 1'b1;
         else if (reenc_ack)         busy_q <= 1'b0;
         if (ld_valid)    dirty_q <= 1'b0;
         else if (accept) dirty_q <= 1'b1;
         else if (wb_ack) dirty_q <= 1'b0;
         if (ld_valid) page_q <= ld_page;
      end
   end

   assign busy       = busy_q;
   assign dirty      = dirty_q;
   assign reenc_page = page_q;
   assign line_out   = {major, bank};
endmodule

// File: rtl/ctr_line_mgr_chk.sv
module ctr_line_mgr_chk #(
   parameter int NUM_BLOCKS = 64,
   parameter int MINOR_W    = 7,
   parameter int MAJOR_W    = 64,
   localparam int IDX_W     = $clog2(NUM_BLOCKS),
   localparam int LINE_W    = NUM_BLOCKS * MINOR_W + MAJOR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid,
   input logic              wr_valid,
   input logic              reenc_ack,
   input logic              rsp_valid,
   input logic [MAJOR_W-1:0] rsp_major,
   input logic              reenc_req,
   input logic              key_req,
   input logic              busy,
   input logic              dirty,
   input logic [LINE_W-1:0] line_out
);
   a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !busy && !ld_valid) |=> rsp_valid);
   a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rsp_valid);
   a_r7_line_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ld_valid) |=> $stable(line_out));
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reenc_req |=> !reenc_req);
   a_r6_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      reenc_req |-> busy);
   a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !reenc_ack) |=> busy);
   a_r8_key_with_reenc: assert property (@(posedge clk) disable iff (!rst_n)
      key_req |-> reenc_req);
   a_r5_major_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !reenc_req) |-> rsp_major == line_out[LINE_W-1 -: MAJOR_W]);
   a_r10_dirty_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> dirty);
endmodule

bind ctr_line_mgr ctr_line_mgr_chk #(
   .NUM_BLOCKS(NUM_BLOCKS), .MINOR_W(MINOR_W), .MAJOR_W(MAJOR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .wr_valid(wr_valid),
   .reenc_ack(reenc_ack), .rsp_valid(rsp_valid), .rsp_major(rsp_major),
   .reenc_req(reenc_req), .key_req(key_req), .busy(busy), .dirty(dirty),
   .line_out(line_out)
);

// File: tb/ctr_line_mgr_test.sv
`timescale 1ns/1ps
module ctr_line_mgr_test;
   localparam int LW = 512;
   localparam int IW = 113;
   localparam logic [35:0] PG1 = 36'h9_ABCD_1234;
   localparam logic [35:0] PG2 = 36'h1_2345_6789;

   localparam int NV = 8;
   localparam logic [5:0] T_IDX [NV] = '{6'd0, 6'd0, 6'd5, 6'd63, 6'd5, 6'd0, 6'd31, 6'd63};
   localparam logic [6:0] T_MIN [NV] = '{7'd1, 7'd2, 7'd1, 7'd1,  7'd2, 7'd3, 7'd1,  7'd2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_valid = 1'b0;
   logic [LW-1:0] ld_line = '0;
   logic [35:0] ld_page = '0;
   logic wr_valid = 1'b0;
   logic [5:0] wr_idx = '0;
   logic reenc_ack = 1'b0;
   logic wb_ack = 1'b0;
   logic rsp_valid;
   logic [6:0] rsp_minor;
   logic [63:0] rsp_major;
   logic [IW-1:0] rsp_iv;
   logic reenc_req;
   logic [35:0] reenc_page;
   logic key_req, busy, dirty;
   logic [LW-1:0] line_out;

   int n_run = 0;
   int n_fail = 0;
   logic [LW-1:0] exp_line;

   always #5 clk = ~clk;

   ctr_line_mgr uut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_line(ld_line),
      .ld_page(ld_page), .wr_valid(wr_valid), .wr_idx(wr_idx),
      .reenc_ack(reenc_ack), .wb_ack(wb_ack), .rsp_valid(rsp_valid),
      .rsp_minor(rsp_minor), .rsp_major(rsp_major), .rsp_iv(rsp_iv),
      .reenc_req(reenc_req), .reenc_page(reenc_page), .key_req(key_req),
      .busy(busy), .dirty(dirty), .line_out(line_out)
   );

   task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] put_minor(input logic [LW-1:0] l, input int i, input logic [6:0] v);
      logic [LW-1:0] r = l;
      r[7*i +: 7] = v;
      return r;
   endfunction

   task automatic do_load(input logic [LW-1:0] l, input logic [35:0] p);
      @(negedge clk); ld_valid = 1'b1; ld_line = l; ld_page = p;
      @(negedge clk); ld_valid = 1'b0;
   endtask

   task automatic do_write(input logic [5:0] i);
      @(negedge clk); wr_valid = 1'b1; wr_idx = i;
      @(negedge clk); wr_valid = 1'b0;
   endtask

   task automatic pulse_reenc_ack();
      @(negedge clk); reenc_ack = 1'b1;
      @(negedge clk); reenc_ack = 1'b0;
   endtask

   task automatic pulse_wb_ack();
      @(negedge clk); wb_ack = 1'b1;
      @(negedge clk); wb_ack = 1'b0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 line", line_out, '0);
      chk("R1 flags", LW'({rsp_valid, reenc_req, key_req, busy, dirty}), '0);
      rst_n = 1'b1;

      do_load('0, PG1);
      exp_line = '0;
      chk("R9 dirty after load", LW'(dirty), '0);

      // Table walk: R2, R3, R4, R10
      for (int k = 0; k < NV; k++) begin
         do_write(T_IDX[k]);
         exp_line = put_minor(exp_line, int'(T_IDX[k]), T_MIN[k]);
         chk("R2 rsp_valid", LW'(rsp_valid), LW'(1));
         chk("R2 minor", LW'(rsp_minor), LW'(T_MIN[k]));
         chk("R2 major", LW'(rsp_major), '0);
         chk("R4 iv", LW'(rsp_iv), LW'({PG1, T_IDX[k], T_MIN[k], 64'd0}));
         chk("R3 line", line_out, exp_line);
         chk("R10 dirty set", LW'(dirty), LW'(1));
      end
      @(negedge clk);
      chk("R2 single-cycle rsp", LW'(rsp_valid), '0);
      pulse_wb_ack();
      chk("R10 dirty cleared", LW'(dirty), '0);

      // Minor wrap: R5, R6, R7
      exp_line = '0;
      exp_line[511:448] = 64'd5;
      exp_line = put_minor(exp_line, 7, 7'd126);
      exp_line = put_minor(exp_line, 9, 7'd40);
      do_load(exp_line, PG2);
      do_write(6'd7);
      chk("R2 minor to 127", LW'(rsp_minor), LW'(7'd127));
      chk("R2 no reenc", LW'(reenc_req), '0);
      do_write(6'd7);
      exp_line = '0;
      exp_line[511:448] = 64'd6;
      exp_line = put_minor(exp_line, 7, 7'd1);
      chk("R5 rsp minor", LW'(rsp_minor), LW'(1));
      chk("R5 rsp major", LW'(rsp_major), LW'(64'd6));
      chk("R5 line cleared", line_out, exp_line);
      chk("R4 iv after wrap", LW'(rsp_iv), LW'({PG2, 6'd7, 7'd1, 64'd6}));
      chk("R6 reenc pulse", LW'(reenc_req), LW'(1));
      chk("R6 reenc page", LW'(reenc_page), LW'(PG2));
      chk("R6 busy", LW'(busy), LW'(1));
      chk("R8 no key", LW'(key_req), '0);
      @(negedge clk);
      chk("R6 pulse ends", LW'(reenc_req), '0);
      chk("R6 busy held", LW'(busy), LW'(1));
      do_write(6'd3);
      chk("R7 no rsp", LW'(rsp_valid), '0);
      chk("R7 line unchanged", line_out, exp_line);
      pulse_reenc_ack();
      chk("R6 busy released", LW'(busy), '0);
      do_write(6'd3);
      chk("R7 write after release", LW'({rsp_minor, rsp_major}), LW'({7'd1, 64'd6}));

      // Major wrap: R8
      exp_line = '0;
      exp_line[511:448] = '1;
      exp_line = put_minor(exp_line, 2, 7'd127);
      do_load(exp_line, PG1);
      do_write(6'd2);
      chk("R8 major wraps", LW'(rsp_major), '0);
      chk("R8 key pulse", LW'(key_req), LW'(1));
      chk("R8 reenc too", LW'(reenc_req), LW'(1));
      chk("R8 line", line_out, put_minor('0, 2, 7'd1));
      @(negedge clk);
      chk("R8 key ends", LW'(key_req), '0);
      pulse_reenc_ack();

      // Load beats write in the same cycle: R9
      do_write(6'd1);
      chk("R10 dirty before load", LW'(dirty), LW'(1));
      exp_line = '0;
      exp_line[511:448] = 64'h77;
      exp_line = put_minor(exp_line, 0, 7'd9);
      @(negedge clk);
      ld_valid = 1'b1; ld_line = exp_line; ld_page = PG2;
      wr_valid = 1'b1; wr_idx = 6'd0;
      @(negedge clk);
      ld_valid = 1'b0; wr_valid = 1'b0;
      chk("R9 write ignored", LW'(rsp_valid), '0);
      chk("R9 line loaded", line_out, exp_line);
      chk("R9 dirty cleared", LW'(dirty), '0);
      chk("R9 page loaded", LW'(reenc_page), LW'(PG2));

      finish_run();
   end
endmodule